// File: doc/BRIEF.md
# Four-Beat Burst Address Sequencer

This block produces the address for each beat of a short burst. A load cycle captures a full starting address from outside the block. Each later continue cycle moves the low address bits on to the next beat of the burst. The upper bits keep the value they took at the load. The low field is `BEAT_W` bits wide and holds 2 bits by default, which gives a burst of four beats. When the burst runs past its last beat it wraps back to the starting beat.

Two beat orders are available. In interleaved order the low bits are the starting bits XOR a beat index. In linear order they are the starting bits plus the beat index, counted modulo the burst length, so the burst stays inside its aligned group. An order-select input picks the order. It is meant to be tied high or low. Tied high is the default and selects interleaved order. The block samples this input only on a load cycle.

A hold input stalls the block completely. The output address is a register and changes only on a rising clock edge after a load or a continue cycle.

Top module: `burst_addr_gen`

## Requirements
- R1: One clock after a cycle with `rst` high, `cur_addr` is 0, the beat index is 0 and the stored order is interleaved.
- R2: A cycle with `hold`=0 and `advance`=0 is a load. After that edge `cur_addr` equals the `ext_addr` of the load cycle, and the burst restarts at beat 0.
- R3: In interleaved order (`interleave_sel`=1 at the load), the low bits after the k-th continue are start XOR k. From start 01 the sequence is 01, 00, 11, 10. From start 10 it is 10, 11, 00, 01.
- R4: In linear order (`interleave_sel`=0 at the load), the low bits after the k-th continue are (start + k) mod 4. From start 01 the sequence is 01, 10, 11, 00. From start 11 it is 11, 00, 01, 10.
- R5: After every fourth continue since the load, the low bits equal the starting low bits again, and the sequence repeats.
- R6: A continue cycle (`hold`=0, `advance`=1) leaves `cur_addr[ADDR_W-1:BEAT_W]` unchanged. It also ignores `ext_addr`.
- R7: A cycle with `hold`=1 leaves `cur_addr` unchanged, whatever `advance` and `ext_addr` are. It also keeps the beat position, so the next continue goes on to the following beat.
- R8: A change of `interleave_sel` between loads has no effect on the order of the burst in progress.
- R9: Continue cycles after reset with no load in between run from start 0 in interleaved order: 01, 10, 11, 00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| hold | input | 1 | 1 stalls the block for the cycle |
| advance | input | 1 | 1 = continue to the next beat, 0 = load `ext_addr` |
| ext_addr | input | ADDR_W | Starting address, captured on a load |
| interleave_sel | input | 1 | 1 = interleaved order, 0 = linear order; sampled on a load |
| cur_addr | output | ADDR_W | Registered address of the current beat |

## Verification
Two situations are hard to reach from the ports. The first is a stall or a change of the order input in the middle of a burst, just before the wrap beat, where a wrong implementation would lose or re-time the beat position. Directed sequences put a hold and a flip of `interleave_sel` right at the third and fourth continue. The second is a long run of continues with random holds. A random phase draws hold, load and continue with weights that favour runs of continues, so that many bursts pass through two or more wraps in both orders.

// File: rtl/burst_pkg.sv
package burst_pkg;
  typedef enum logic {
    ORDER_LINEAR      = 1'b0,
    ORDER_INTERLEAVED = 1'b1
  } burst_order_e;
endpackage

// File: rtl/burst_beat_ctr.sv
module burst_beat_ctr #(
  parameter int BEAT_W = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clr,
  input  logic              step,
  output logic [BEAT_W-1:0] idx_next
);
  logic [BEAT_W-1:0] idx_q;

  assign idx_next = idx_q + BEAT_W'(1);

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      idx_q <= '0;
    end else if (step) begin
      idx_q <= idx_next;
    end
  end
endmodule

// File: rtl/burst_order_map.sv
module burst_order_map
  import burst_pkg::*;
#(
  parameter int BEAT_W = 2
) (
  input  logic [BEAT_W-1:0] start_lo,
  input  logic [BEAT_W-1:0] beat,
  input  burst_order_e      order,
  output logic [BEAT_W-1:0] addr_lo
);
  logic [BEAT_W-1:0] xor_lo;
  logic [BEAT_W-1:0] add_lo;

  for (genvar b = 0; b < BEAT_W; b++) begin : g_xor
    assign xor_lo[b] = start_lo[b] ^ beat[b];
  end

  assign add_lo  = start_lo + beat;
  assign addr_lo = (order == ORDER_INTERLEAVED) ? xor_lo : add_lo;
endmodule

// File: rtl/burst_addr_reg.sv
module burst_addr_reg
  import burst_pkg::*;
#(
  parameter int ADDR_W = 18,
  parameter int BEAT_W = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic              step,
  input  logic [ADDR_W-1:0] ext_addr,
  input  logic              sel_in,
  input  logic [BEAT_W-1:0] next_lo,
  output logic [BEAT_W-1:0] start_q,
  output burst_order_e      order_q,
  output logic [ADDR_W-1:0] addr_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      addr_q  <= '0;
      start_q <= '0;
      order_q <= ORDER_INTERLEAVED;
    end else if (load) begin
      addr_q  <= ext_addr;
      start_q <= ext_addr[BEAT_W-1:0];
      order_q <= burst_order_e'(sel_in);
    end else if (step) begin
      addr_q[BEAT_W-1:0] <= next_lo;
    end
  end
endmodule

// File: rtl/burst_addr_gen.sv
module burst_addr_gen
  import burst_pkg::*;
#(
  parameter int ADDR_W = 18,
  parameter int BEAT_W = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              hold,
  input  logic              advance,
  input  logic [ADDR_W-1:0] ext_addr,
  input  logic              interleave_sel,
  output logic [ADDR_W-1:0] cur_addr
);
  logic              do_load;
  logic              do_step;
  logic [BEAT_W-1:0] beat_nx;
  logic [BEAT_W-1:0] start_q;
  logic [BEAT_W-1:0] next_lo;
  burst_order_e      order_q;

  assign do_load = !hold && !advance;
  assign do_step = !hold && advance;

  burst_beat_ctr #(.BEAT_W(BEAT_W)) beat_i (
    .clk      (clk),
    .rst      (rst),
    .clr      (do_load),
    .step     (do_step),
    .idx_next (beat_nx)
  );

  burst_order_map #(.BEAT_W(BEAT_W)) map_i (
    .start_lo (start_q),
    .beat     (beat_nx),
    .order    (order_q),
    .addr_lo  (next_lo)
  );

  burst_addr_reg #(.ADDR_W(ADDR_W), .BEAT_W(BEAT_W)) reg_i (
    .clk      (clk),
    .rst      (rst),
    .load     (do_load),
    .step     (do_step),
    .ext_addr (ext_addr),
    .sel_in   (interleave_sel),
    .next_lo  (next_lo),
    .start_q  (start_q),
    .order_q  (order_q),
    .addr_q   (cur_addr)
  );
endmodule

// File: rtl/burst_addr_gen_chk.sv
module burst_addr_gen_chk
  import burst_pkg::*;
#(
  parameter int ADDR_W = 18,
  parameter int BEAT_W = 2
) (
  input logic              clk,
  input logic              rst,
  input logic              hold,
  input logic              advance,
  input logic [ADDR_W-1:0] ext_addr,
  input logic [ADDR_W-1:0] cur_addr,
  input burst_order_e      order_q
);
  logic [BEAT_W-1:0] seen_start;
  logic [BEAT_W-1:0] steps;

  always_ff @(posedge clk) begin
    if (rst) begin
      seen_start <= '0;
      steps      <= '0;
    end else if (!hold && !advance) begin
      seen_start <= ext_addr[BEAT_W-1:0];
      steps      <= '0;
    end else if (!hold) begin
      steps <= steps + BEAT_W'(1);
    end
  end

  // R1
  reset_zero_chk: assert property (@(posedge clk) rst |=> cur_addr == '0);

  // R2
  load_capture_chk: assert property (@(posedge clk) disable iff (rst)
    (!hold && !advance) |=> cur_addr == $past(ext_addr));

  // R7
  hold_stable_chk: assert property (@(posedge clk) disable iff (rst)
    hold |=> $stable(cur_addr));

  // R6
  upper_kept_chk: assert property (@(posedge clk) disable iff (rst)
    (!hold && advance) |=> cur_addr[ADDR_W-1:BEAT_W] == $past(cur_addr[ADDR_W-1:BEAT_W]));

  // R4
  linear_step_chk: assert property (@(posedge clk) disable iff (rst)
    (!hold && advance && order_q == ORDER_LINEAR) |=>
      cur_addr[BEAT_W-1:0] == $past(cur_addr[BEAT_W-1:0]) + BEAT_W'(1));

  // R3
  interleave_step_chk: assert property (@(posedge clk) disable iff (rst)
    (!hold && advance && order_q == ORDER_INTERLEAVED) |=>
      (cur_addr[BEAT_W-1:0] ^ $past(cur_addr[BEAT_W-1:0])) ==
      ($past(steps) ^ ($past(steps) + BEAT_W'(1))));

  // R5
  wrap_start_chk: assert property (@(posedge clk) disable iff (rst)
    (!hold && advance && steps == {BEAT_W{1'b1}}) |=>
      cur_addr[BEAT_W-1:0] == $past(seen_start));
endmodule

bind burst_addr_gen burst_addr_gen_chk #(.ADDR_W(ADDR_W), .BEAT_W(BEAT_W)) chk_i (
  .clk      (clk),
  .rst      (rst),
  .hold     (hold),
  .advance  (advance),
  .ext_addr (ext_addr),
  .cur_addr (cur_addr),
  .order_q  (order_q)
);

// File: tb/burst_addr_gen_tb_top.sv
`timescale 1ns/1ps
module burst_addr_gen_tb_top;
  localparam int AW = 18;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          hold = 1'b0;
  logic          advance = 1'b0;
  logic [AW-1:0] ext_addr = '0;
  logic          interleave_sel = 1'b1;
  logic [AW-1:0] cur_addr;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  logic [1:0]    m_start;
  logic [1:0]    m_k;
  logic          m_mode;
  logic [AW-1:0] m_addr;

  always #2 clk = ~clk;

  burst_addr_gen #(.ADDR_W(AW), .BEAT_W(2)) dut_i (
    .clk(clk), .rst(rst), .hold(hold), .advance(advance),
    .ext_addr(ext_addr), .interleave_sel(interleave_sel), .cur_addr(cur_addr)
  );

  function automatic logic [1:0] beat_lo(logic [1:0] s, logic [1:0] k, logic mode);
    return mode ? (s ^ k) : (s + k);
  endfunction

  task automatic check(string tag, logic [AW-1:0] act, logic [AW-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic cyc(logic h, logic a, logic [AW-1:0] addr, logic m);
    string tag;
    logic [AW-1:0] prev;
    @(negedge clk);
    hold = h; advance = a; ext_addr = addr; interleave_sel = m;
    prev = m_addr;
    @(posedge clk);
    if (h) begin
      tag = "R7";
    end else if (!a) begin
      m_addr = addr; m_start = addr[1:0]; m_k = 2'd0; m_mode = m; tag = "R2";
    end else begin
      m_k = m_k + 2'd1;
      m_addr = {m_addr[AW-1:2], beat_lo(m_start, m_k, m_mode)};
      if (m_k == 2'd0) tag = "R5";
      else if (m != m_mode) tag = "R8";
      else tag = m_mode ? "R3" : "R4";
    end
    #1;
    check(tag, cur_addr, m_addr);
    if (!h && a) check("R6", {cur_addr[AW-1:2], 2'b00}, {prev[AW-1:2], 2'b00});
  endtask

  task automatic low_is(string tag, logic [1:0] exp);
    check(tag, {{(AW-2){1'b0}}, cur_addr[1:0]}, {{(AW-2){1'b0}}, exp});
  endtask

  initial begin
    int unsigned seed;
    seed = 32'h5eed_1234;
    void'($urandom(seed));
    m_start = 2'd0; m_k = 2'd0; m_mode = 1'b1; m_addr = '0;
    rst = 1'b1;
    @(posedge clk); @(posedge clk);
    #1;
    check("R1", cur_addr, '0);
    @(negedge clk); rst = 1'b0;

    // R9: continue straight after reset, interleaved from 0
    cyc(0, 1, 18'h3ffff, 0); low_is("R9", 2'b01);
    cyc(0, 1, 18'h00000, 0); low_is("R9", 2'b10);
    cyc(0, 1, 18'h12345, 0); low_is("R9", 2'b11);
    cyc(0, 1, 18'h00000, 0); low_is("R9", 2'b00);

    // R3 interleaved from 01
    cyc(0, 0, 18'h2a5c1, 1); low_is("R3", 2'b01);
    cyc(0, 1, 18'h0, 1); low_is("R3", 2'b00);
    cyc(0, 1, 18'h0, 1); low_is("R3", 2'b11);
    cyc(0, 1, 18'h0, 1); low_is("R3", 2'b10);
    cyc(0, 1, 18'h0, 1); low_is("R5", 2'b01);
    // R3 interleaved from 10
    cyc(0, 0, 18'h1fff2, 1); low_is("R3", 2'b10);
    cyc(0, 1, 18'h0, 1); low_is("R3", 2'b11);
    cyc(0, 1, 18'h0, 1); low_is("R3", 2'b00);
    cyc(0, 1, 18'h0, 1); low_is("R3", 2'b01);
    // R4 linear from 01, mode flipped mid-burst (R8), hold before wrap (R7)
    cyc(0, 0, 18'h30005, 0); low_is("R4", 2'b01);
    cyc(0, 1, 18'h0, 1); low_is("R8", 2'b10);
    cyc(0, 1, 18'h0, 1); low_is("R8", 2'b11);
    cyc(1, 0, 18'h3ffff, 1); low_is("R7", 2'b11);
    cyc(1, 1, 18'h3ffff, 0); low_is("R7", 2'b11);
    cyc(0, 1, 18'h0, 1); low_is("R4", 2'b00);
    cyc(0, 1, 18'h0, 1); low_is("R5", 2'b01);
    // R4 linear from 11
    cyc(0, 0, 18'h0000f, 0); low_is("R4", 2'b11);
    cyc(0, 1, 18'h0, 0); low_is("R4", 2'b00);
    cyc(0, 1, 18'h0, 0); low_is("R4", 2'b01);
    cyc(0, 1, 18'h0, 0); low_is("R4", 2'b10);
    cyc(0, 1, 18'h0, 0); low_is("R5", 2'b11);

    // random phase
    for (int i = 0; i < 3000; i++) begin
      int unsigned r;
      r = $urandom_range(0, 99);
      cyc(r < 15, r >= 30, AW'($urandom), ($urandom_range(0, 9) < 8) ? m_mode : 1'($urandom));
    end

    // reset mid-burst
    @(negedge clk); rst = 1'b1;
    @(posedge clk); #1;
    check("R1", cur_addr, '0);
    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(4 * 200000);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule